// File: doc/BRIEF.md
# Dual-Bank Pixel Color Matrix Converter

This block converts a stream of three-component pixels from one color space to another. Each output component is a weighted sum of the three input components plus a constant offset. Twelve signed fixed-point coefficients, arranged as three rows of four, hold the weights and offsets. The result is rounded to nearest and clamped to the unsigned component range. Pixels enter with a valid strobe and leave, still qualified by a valid strobe, after a fixed pipeline delay that does not depend on the selected mode.

Two programmable coefficient banks sit behind a single register write port. While one bank drives the datapath, software fills the other bank. It then flips the mode word to make the new bank live. Writes aimed at the live bank are dropped, so a pixel never sees a half-updated matrix. The mode word can also select a plain pass-through or one of two built-in RGB-to-YCbCr matrices: one with standard-definition weights and one with high-definition weights.

Top module: `dual_bank_csc`

## Requirements
- R1: After reset, outValid and pixOut are 0, the mode is pass-through, and every coefficient of both banks is 0. Selecting bank A straight after reset therefore gives all-zero output pixels.
- R2: A pixel accepted on the clock edge where inValid is 1 appears on pixOut with outValid 1 after the third rising edge, counting the accepting edge as the first. This holds in every mode, including back-to-back and gapped streams. outValid is 0 in cycles with no pixel to present.
- R3: Mode code 0 is pass-through: each output component equals the matching input component exactly. Input component k is carried on pixIn bits [k*12 +: 12] and output row k on pixOut bits [k*12 +: 12].
- R4: Output row r equals clamp(floor((C(r,1)*in0 + C(r,2)*in1 + C(r,3)*in2 + C(r,4)*4096 + 4096) / 8192)). Multipliers and offsets are 16-bit two's complement with 13 fractional bits (0x2000 = 1.0). The offset is scaled to the full component range.
- R5: Register addresses 0..5 load bank A and 6..11 load bank B. Each address holds the coefficient pair (C11,C12), (C13,C14), (C21,C22), (C23,C24), (C31,C32), (C33,C34) in that order. The first coefficient of a pair sits in bits [15:0] and the second in bits [31:16]. Address 12 is the mode word, with the code in bits [2:0].
- R6: Mode code 4 runs the pixel stream through bank A. Mode code 5 runs it through bank B.
- R7: Mode code 2 applies the fixed matrix with rows (2449, 4809, 934, 0), (-1382, -2714, 4096, 4096) and (4096, -3430, -666, 4096).
- R8: Mode code 3 applies the fixed matrix with rows (1742, 5859, 591, 0), (-939, -3157, 4096, 4096) and (4096, -3720, -376, 4096).
- R9: While mode 4 is active, writes to addresses 0..5 are ignored. While mode 5 is active, writes to addresses 6..11 are ignored. The idle bank stays writable.
- R10: A pixel accepted on the same edge as a mode write uses the old mode. The next pixel accepted uses the new mode. No pixel mixes coefficients from two banks.
- R11: Writes of mode codes 1, 6 or 7, and writes to addresses 13..15, change nothing.
- R12: Results below 0 clamp to 0 and results above 4095 clamp to 4095. An exact half rounds upward.
- R13: A bank loaded with 0x2000 on the diagonal and 0 elsewhere reproduces the input pixel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 4 | Register word address |
| regWrData | input | 32 | Register write data (coefficient pair or mode word) |
| inValid | input | 1 | Input pixel qualifier |
| pixIn | input | 36 | Input pixel, three 12-bit unsigned components |
| outValid | output | 1 | Output pixel qualifier |
| pixOut | output | 36 | Output pixel, three 12-bit unsigned components |

## Verification
The embedded properties assume the following about the inputs:
- Only one register word is written per cycle.
- Reset is held low across at least one rising edge before the first write or pixel.
- inValid is a clean 0 or 1 at every edge.

The stimulus keeps to these rules. It drives all inputs on the falling edge and releases reset only after several low-reset edges. It never issues a mode write and a coefficient write in the same cycle. The one case of a pixel coinciding with a mode write is produced on purpose, to exercise the switching edge.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int ROWS      = 3;
  localparam int COLS      = 4;
  localparam int NUM_COEF  = ROWS * COLS;
  localparam int PAIR_WORDS = NUM_COEF / 2;
  localparam int CTRL_ADDR = 2 * PAIR_WORDS;
  localparam int FRAC_W    = 13;

  typedef enum logic [2:0] {
    MODE_PASS   = 3'd0,
    MODE_FIX601 = 3'd2,
    MODE_FIX709 = 3'd3,
    MODE_BANKA  = 3'd4,
    MODE_BANKB  = 3'd5
  } cscMode_e;

  // one-hot matrix selection passed from control to datapath
  typedef struct packed {
    logic pass;
    logic fix601;
    logic fix709;
    logic bankA;
    logic bankB;
  } matSel_t;

  function automatic logic modeCodeOk(input logic [2:0] code);
    return (code == 3'd0) || (code == 3'd2) || (code == 3'd3) ||
           (code == 3'd4) || (code == 3'd5);
  endfunction

  function automatic int identityCoef(input int idx);
    return ((idx % COLS) == (idx / COLS)) ? (1 << FRAC_W) : 0;
  endfunction

  // built-in RGB to YCbCr weights, 13 fractional bits, row-major
  function automatic int fixedCoef(input logic hd, input int idx);
    int v;
    v = 0;
    if (!hd) begin
      case (idx)
        0: v = 2449;   1: v = 4809;   2: v = 934;    3: v = 0;
        4: v = -1382;  5: v = -2714;  6: v = 4096;   7: v = 4096;
        8: v = 4096;   9: v = -3430; 10: v = -666;  11: v = 4096;
        default: v = 0;
      endcase
    end else begin
      case (idx)
        0: v = 1742;   1: v = 5859;   2: v = 591;    3: v = 0;
        4: v = -939;   5: v = -3157;  6: v = 4096;   7: v = 4096;
        8: v = 4096;   9: v = -3720; 10: v = -376;  11: v = 4096;
        default: v = 0;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/csc_ctrl.sv
module csc_ctrl
  import csc_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [2*COEF_W-1:0]              wrData,
  output logic [NUM_COEF-1:0][COEF_W-1:0]  bankA,
  output logic [NUM_COEF-1:0][COEF_W-1:0]  bankB,
  output matSel_t                          sel
);

  cscMode_e modeQ;
  logic     liveA;
  logic     liveB;

  assign liveA = (modeQ == MODE_BANKA);
  assign liveB = (modeQ == MODE_BANKB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_PASS;
      for (int i = 0; i < NUM_COEF; i++) begin
        bankA[i] <= '0;
        bankB[i] <= '0;
      end
    end else if (wrEn) begin
      for (int w = 0; w < PAIR_WORDS; w++) begin
        if (wrAddr == ADDR_W'(w) && !liveA) begin
          bankA[2*w]   <= wrData[COEF_W-1:0];
          bankA[2*w+1] <= wrData[2*COEF_W-1:COEF_W];
        end
        if (wrAddr == ADDR_W'(w + PAIR_WORDS) && !liveB) begin
          bankB[2*w]   <= wrData[COEF_W-1:0];
          bankB[2*w+1] <= wrData[2*COEF_W-1:COEF_W];
        end
      end
      if (wrAddr == ADDR_W'(CTRL_ADDR) && modeCodeOk(wrData[2:0]))
        modeQ <= cscMode_e'(wrData[2:0]);
    end
  end

  always_comb begin
    sel = '0;
    case (modeQ)
      MODE_FIX601: sel.fix601 = 1'b1;
      MODE_FIX709: sel.fix709 = 1'b1;
      MODE_BANKA:  sel.bankA  = 1'b1;
      MODE_BANKB:  sel.bankB  = 1'b1;
      default:     sel.pass   = 1'b1;
    endcase
  end

  // R9
  liveAHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    liveA |=> $stable(bankA));

  // R9
  liveBHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    liveB |=> $stable(bankB));

  // R11
  modeLegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeCodeOk(modeQ));

endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int COMP_W = 12,
  parameter int COEF_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            inValid,
  input  logic [ROWS*COMP_W-1:0]          pixIn,
  input  logic [NUM_COEF-1:0][COEF_W-1:0] bankA,
  input  logic [NUM_COEF-1:0][COEF_W-1:0] bankB,
  input  matSel_t                         sel,
  output logic                            outValid,
  output logic [ROWS*COMP_W-1:0]          pixOut
);

  localparam int PROD_W   = COMP_W + 1 + COEF_W;
  localparam int ACC_W    = PROD_W + 3;
  localparam int COMP_MAX = (1 << COMP_W) - 1;
  localparam int HALF     = 1 << (FRAC_W - 1);

  logic                     v1Q;
  logic                     v2Q;
  logic [COMP_W-1:0]        compIn  [ROWS];
  logic signed [COEF_W-1:0] coefNow [NUM_COEF];

  always_comb begin
    for (int c = 0; c < ROWS; c++) compIn[c] = pixIn[c*COMP_W +: COMP_W];
  end

  // matrix source chosen at the accepting edge only
  always_comb begin
    for (int i = 0; i < NUM_COEF; i++) begin
      if (sel.bankA)       coefNow[i] = bankA[i];
      else if (sel.bankB)  coefNow[i] = bankB[i];
      else if (sel.fix601) coefNow[i] = COEF_W'(fixedCoef(1'b0, i));
      else if (sel.fix709) coefNow[i] = COEF_W'(fixedCoef(1'b1, i));
      else                 coefNow[i] = COEF_W'(identityCoef(i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1Q      <= 1'b0;
      v2Q      <= 1'b0;
      outValid <= 1'b0;
    end else begin
      v1Q      <= inValid;
      v2Q      <= v1Q;
      outValid <= v2Q;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic signed [PROD_W-1:0] prodNext [ROWS];
    logic signed [PROD_W-1:0] prodQ    [ROWS];
    logic signed [COEF_W-1:0] offQ;
    logic signed [ACC_W-1:0]  sumNext;
    logic signed [ACC_W-1:0]  sumQ;
    logic signed [ACC_W-1:0]  rounded;
    logic signed [ACC_W-1:0]  scaled;
    logic [COMP_W-1:0]        outNext;
    logic [COMP_W-1:0]        outQ;

    // stage 1: products captured together with the offset
    always_comb begin
      for (int k = 0; k < ROWS; k++) begin
        prodNext[k] = $signed({{(PROD_W-COMP_W){1'b0}}, compIn[k]}) *
                      $signed({{(PROD_W-COEF_W){coefNow[r*COLS+k][COEF_W-1]}},
                               coefNow[r*COLS+k]});
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < ROWS; k++) prodQ[k] <= '0;
        offQ <= '0;
      end else if (inValid) begin
        for (int k = 0; k < ROWS; k++) prodQ[k] <= prodNext[k];
        offQ <= coefNow[r*COLS + COLS - 1];
      end
    end

    // stage 2: full-precision sum
    always_comb begin
      sumNext = ACC_W'(prodQ[0]) + ACC_W'(prodQ[1]) + ACC_W'(prodQ[2]) +
                (ACC_W'(offQ) <<< COMP_W);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    sumQ <= '0;
      else if (v1Q) sumQ <= sumNext;
    end

    // stage 3: round half up, then clamp
    always_comb begin
      rounded = sumQ + ACC_W'(HALF);
      scaled  = rounded >>> FRAC_W;
      if (scaled < 0)                    outNext = '0;
      else if (scaled > ACC_W'(COMP_MAX)) outNext = '1;
      else                               outNext = scaled[COMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    outQ <= '0;
      else if (v2Q) outQ <= outNext;
    end

    assign pixOut[r*COMP_W +: COMP_W] = outQ;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##2 outValid);

  // R3
  bypassExact_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sel.pass) |=> ##2 (pixOut == $past(pixIn, 3)));

endmodule

// File: rtl/dual_bank_csc.sv
module dual_bank_csc
  import csc_pkg::*;
#(
  parameter int COMP_W = 12,
  parameter int COEF_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [ADDR_W-1:0]      regWrAddr,
  input  logic [2*COEF_W-1:0]    regWrData,
  input  logic                   inValid,
  input  logic [ROWS*COMP_W-1:0] pixIn,
  output logic                   outValid,
  output logic [ROWS*COMP_W-1:0] pixOut
);

  logic [NUM_COEF-1:0][COEF_W-1:0] bankA;
  logic [NUM_COEF-1:0][COEF_W-1:0] bankB;
  matSel_t                         sel;

  csc_ctrl #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (regWrEn),
    .wrAddr (regWrAddr),
    .wrData (regWrData),
    .bankA  (bankA),
    .bankB  (bankB),
    .sel    (sel)
  );

  csc_datapath #(.COMP_W(COMP_W), .COEF_W(COEF_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .pixIn    (pixIn),
    .bankA    (bankA),
    .bankB    (bankB),
    .sel      (sel),
    .outValid (outValid),
    .pixOut   (pixOut)
  );

endmodule

// File: tb/tb_dual_bank_csc.sv
module tb_dual_bank_csc;

  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [3:0]  regWrAddr;
  logic [31:0] regWrData;
  logic        inValid;
  logic [35:0] pixIn;
  logic        outValid;
  logic [35:0] pixOut;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  string curReq = "R1";

  // behavioural reference state
  int mMode = 0;
  int mA[12];
  int mB[12];
  bit eV[3];
  logic [35:0] eP[3];

  int t601[12] = '{2449, 4809, 934, 0, -1382, -2714, 4096, 4096, 4096, -3430, -666, 4096};
  int t709[12] = '{1742, 5859, 591, 0, -939, -3157, 4096, 4096, 4096, -3720, -376, 4096};

  dual_bank_csc dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .inValid(inValid), .pixIn(pixIn),
    .outValid(outValid), .pixOut(pixOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [35:0] pk(int a, int b, int c);
    logic [11:0] x, y, z;
    x = 12'(a); y = 12'(b); z = 12'(c);
    return {z, y, x};
  endfunction

  function automatic longint coefOf(int idx);
    case (mMode)
      2: return t601[idx];
      3: return t709[idx];
      4: return mA[idx];
      5: return mB[idx];
      default: return ((idx % 4) == (idx / 4)) ? 8192 : 0;
    endcase
  endfunction

  function automatic logic [35:0] refPix(logic [35:0] p);
    logic [35:0] res;
    res = '0;
    for (int r = 0; r < 3; r++) begin
      longint acc;
      acc = 0;
      for (int c = 0; c < 3; c++) acc += longint'(p[c*W +: W]) * coefOf(r*4 + c);
      acc += coefOf(r*4 + 3) * 4096;
      acc = (acc + 4096) >>> 13;
      if (acc < 0) acc = 0;
      if (acc > 4095) acc = 4095;
      res[r*W +: W] = 12'(acc);
    end
    return res;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0;
      for (int i = 0; i < 12; i++) begin mA[i] = 0; mB[i] = 0; end
      for (int i = 0; i < 3; i++) begin eV[i] = 0; eP[i] = '0; end
    end else begin
      eV[2] = eV[1]; eP[2] = eP[1];
      eV[1] = eV[0]; eP[1] = eP[0];
      eV[0] = inValid; eP[0] = refPix(pixIn);
      if (regWrEn) begin
        int a;
        a = int'(regWrAddr);
        if (a < 6 && mMode != 4) begin
          mA[2*a] = int'($signed(regWrData[15:0]));
          mA[2*a+1] = int'($signed(regWrData[31:16]));
        end else if (a >= 6 && a < 12 && mMode != 5) begin
          mB[2*(a-6)] = int'($signed(regWrData[15:0]));
          mB[2*(a-6)+1] = int'($signed(regWrData[31:16]));
        end else if (a == 12) begin
          int m;
          m = int'(regWrData[2:0]);
          if (m == 0 || m == 2 || m == 3 || m == 4 || m == 5) mMode = m;
        end
      end
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rstN === 1'b1 && !done) begin
      checks++;
      if (outValid !== eV[2] || (eV[2] && pixOut !== eP[2])) begin
        failures++;
        $display("FAIL %s: outValid=%0b pixOut=%h expected outValid=%0b pixOut=%h",
                 curReq, outValid, pixOut, eV[2], eP[2]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(bit v, logic [35:0] p, bit w, int a, logic [31:0] d);
    inValid = v; pixIn = p; regWrEn = w; regWrAddr = 4'(a); regWrData = d;
    @(negedge clk);
    inValid = 0; regWrEn = 0;
  endtask

  task automatic px(int a, int b, int c);
    step(1, pk(a, b, c), 0, 0, 0);
  endtask

  task automatic wr(int a, logic [31:0] d);
    step(0, '0, 1, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0);
  endtask

  task automatic mixPixels();
    px(0, 0, 0); px(4095, 4095, 4095); px(4095, 0, 0);
    px(0, 4095, 0); px(0, 0, 4095); px(1234, 567, 3210); px(17, 2048, 999);
    idle(3);
  endtask

  initial begin
    rstN = 0; inValid = 0; pixIn = '0; regWrEn = 0; regWrAddr = '0; regWrData = '0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (outValid !== 1'b0 || pixOut !== '0) begin
        failures++;
        $display("FAIL R1: outValid=%0b pixOut=%h expected outValid=0 pixOut=0", outValid, pixOut);
      end
      @(negedge clk);
    end
    rstN = 1;
    idle(2);

    curReq = "R3";
    mixPixels();

    curReq = "R2";
    px(10, 20, 30); px(40, 50, 60); idle(1); px(70, 80, 90); idle(2);
    px(1, 2, 3); idle(4);

    curReq = "R1";
    wr(12, 32'd4); px(100, 200, 300); px(4095, 4095, 4095); idle(3);

    curReq = "R7";
    wr(12, 32'd2); mixPixels();

    curReq = "R8";
    wr(12, 32'd3); mixPixels();

    curReq = "R5";
    wr(0, 32'h0000_2000); wr(1, 32'h0); wr(2, 32'h2000_0000);
    wr(3, 32'h0); wr(4, 32'h0); wr(5, 32'h0000_2000);
    wr(12, 32'd4);

    curReq = "R13";
    mixPixels();

    curReq = "R9";
    for (int a = 0; a < 6; a++) wr(a, 32'h1234_8765);
    mixPixels();

    curReq = "R6";
    wr(6, 32'h0000_1B60); wr(7, 32'h0200_0000); wr(8, 32'h0000_1B60);
    wr(9, 32'h0200_0000); wr(10, 32'h0); wr(11, 32'h0200_1B60);
    wr(12, 32'd5);
    mixPixels();

    curReq = "R9";
    for (int a = 6; a < 12; a++) wr(a, 32'hE000_4000);
    mixPixels();

    curReq = "R12";
    wr(0, 32'h0000_4000); wr(1, 32'h0); wr(2, 32'h0000_E000);
    wr(3, 32'h0); wr(4, 32'h0000_1000); wr(5, 32'h0);

    curReq = "R10";
    px(3000, 100, 200);
    step(1, pk(3000, 100, 200), 1, 12, 32'd4);
    px(3000, 100, 200);
    idle(3);

    curReq = "R12";
    px(4095, 4095, 4095); px(1, 0, 0); px(3, 0, 0); px(2048, 0, 0);
    px(2047, 0, 0); px(5, 0, 0); px(0, 0, 0);
    idle(3);

    curReq = "R11";
    wr(12, 32'd1); px(1, 2, 3);
    wr(12, 32'd6); px(4095, 0, 0);
    wr(12, 32'd7); px(3, 0, 0);
    wr(13, 32'd0); wr(14, 32'd5); wr(15, 32'd2);
    px(2000, 1, 1); idle(3);

    curReq = "R4";
    wr(12, 32'd5); mixPixels();
    wr(12, 32'd2);
    px(300, 600, 900); px(4000, 100, 50); px(50, 100, 4000); idle(3);

    curReq = "R2";
    wr(12, 32'd3);
    for (int i = 0; i < 20; i++) px(i * 200, 4095 - i * 150, (i * 377) % 4096);
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule